// File: doc/BRIEF.md
# Read Latency Histogram Monitor

This block watches the read side of an AXI memory port without driving it. Every accepted read address is stamped with a free-running cycle count and queued under its transaction ID. Each returned data beat is matched to the oldest open transaction of the same ID. The elapsed cycle count then decides which of five latency bins is incremented.

The bins span 0 to 127 cycles, followed by four bands of 64 cycles that end at 383. A beat that takes longer falls in no bin. Software obtains the count of these slow beats by subtracting the five bins from the total beat counter, which the block also keeps. A further counter records the cycles in which a read address is offered but not accepted. All seven counters are read through a combinational select port.

Top module: `rd_lat_hist`

## Requirements
- R1: After reset, all seven counters read zero.
- R2: Latency is the number of clock edges from the edge that accepts the read address to the edge that transfers the beat. A latency below 128 increments bin 0. A latency in 128..383 increments bin 1 + (latency-128)/64. At most one bin increments per cycle.
- R3: A beat with a latency of 384 cycles or more increments no bin but still increments the beat counter.
- R4: The beat counter increments once for every edge with r_valid and r_ready both high, whatever the ID and whether or not a transaction is open. A beat with r_valid high and r_ready low counts nowhere.
- R5: The stall counter increments once for every edge with ar_valid high and ar_ready low.
- R6: Transactions that share an ID are kept in order. Every beat of a burst is timed against its own transaction's start. The transaction is retired on the beat with r_last high.
- R7: Different IDs are timed independently, and their bursts may return in any order relative to each other.
- R8: Each ID holds up to 4 open transactions. An address accepted while its ID already holds 4 is not timed. A beat whose ID has no open transaction increments only the beat counter.
- R9: rd_sel picks the value on rd_data: 0 to 4 give bins 0 to 4, 5 gives the beat count, 6 gives the stall count, and 7 gives zero.
- R10: Timestamps are 16 bits wide and the difference is taken modulo 2^16, so a latency that spans a wrap of the cycle counter is still measured correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | 3 | Read address ID |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | 3 | Read data ID |
| r_last | input | 1 | Last beat of a burst |
| rd_sel | input | 3 | Counter select |
| rd_data | output | 32 | Selected counter value |

## Verification
Single reads are placed exactly at each bin edge (127/128, 191/192, 255/256, 319/320, 383/384) and beyond it, so an off-by-one in a boundary or in the timestamp point lands in a different bin. Directed cases cover a queue that overflows, a beat with no open transaction, beats that are withheld, stalled addresses, bursts that share an ID, and two IDs returning out of order. These separate per-ID ordering from global ordering and show when queue release happens. A long idle run pushes a read across the wrap of the cycle counter. Seeded random rounds then mix IDs, burst lengths, gaps and stalls, and every counter is compared with a bench model after each round.

// File: rtl/rd_lat_hist.sv
module rd_lat_hist #(
  parameter int ID_W  = 3,
  parameter int QD_W  = 2,
  parameter int TS_W  = 16,
  parameter int CNT_W = 32,
  parameter int FIRST_HI = 128,
  parameter int BAND  = 64,
  parameter int NBIN  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ar_valid,
  input  logic             ar_ready,
  input  logic [ID_W-1:0]  ar_id,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic [ID_W-1:0]  r_id,
  input  logic             r_last,
  input  logic [2:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data
);
  localparam int NID = 1 << ID_W;
  localparam int QD  = 1 << QD_W;

  logic [TS_W-1:0]  cyc;
  logic [TS_W-1:0]  ts_mem [NID][QD];
  logic [QD_W-1:0]  wp  [NID];
  logic [QD_W-1:0]  rp  [NID];
  logic [QD_W:0]    occ [NID];
  logic [CNT_W-1:0] bin_cnt [NBIN];
  logic [CNT_W-1:0] beat_cnt, stall_cnt;
  logic [NBIN-1:0]  bin_hit;

  wire ar_hs = ar_valid && ar_ready;
  wire r_hs  = r_valid && r_ready;
  wire push  = ar_hs && (occ[ar_id] != (QD_W+1)'(QD));
  wire hit   = r_hs && (occ[r_id] != '0);
  wire pop   = hit && r_last;
  wire [TS_W-1:0] lat = cyc - ts_mem[r_id][rp[r_id]];

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 1'b1;
  end

  always_ff @(posedge clk)
    if (push) ts_mem[ar_id][wp[ar_id]] <= cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NID; i++) begin
        wp[i]  <= '0;
        rp[i]  <= '0;
        occ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NID; i++) begin
        if (push && ar_id == ID_W'(i)) wp[i] <= wp[i] + 1'b1;
        if (pop && r_id == ID_W'(i))   rp[i] <= rp[i] + 1'b1;
        occ[i] <= occ[i] + {{QD_W{1'b0}}, push && ar_id == ID_W'(i)}
                         - {{QD_W{1'b0}}, pop && r_id == ID_W'(i)};
      end
    end
  end

  for (genvar b = 0; b < NBIN; b++) begin : g_bin
    localparam int LO = (b == 0) ? 0 : FIRST_HI + BAND * (b - 1);
    localparam int HI = FIRST_HI + BAND * b;
    assign bin_hit[b] = hit && lat >= TS_W'(LO) && lat < TS_W'(HI);
    always_ff @(posedge clk) begin
      if (!rst_n)          bin_cnt[b] <= '0;
      else if (bin_hit[b]) bin_cnt[b] <= bin_cnt[b] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt  <= '0;
      stall_cnt <= '0;
    end else begin
      if (r_hs) beat_cnt <= beat_cnt + 1'b1;
      if (ar_valid && !ar_ready) stall_cnt <= stall_cnt + 1'b1;
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = bin_cnt[0];
      3'd1:    rd_data = bin_cnt[1];
      3'd2:    rd_data = bin_cnt[2];
      3'd3:    rd_data = bin_cnt[3];
      3'd4:    rd_data = bin_cnt[4];
      3'd5:    rd_data = beat_cnt;
      3'd6:    rd_data = stall_cnt;
      default: rd_data = '0;
    endcase
  end

  logic [CNT_W+2:0] bin_sum;
  always_comb begin
    bin_sum = '0;
    for (int i = 0; i < NBIN; i++) bin_sum = bin_sum + (CNT_W+3)'(bin_cnt[i]);
  end

  // R5
  stall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> stall_cnt == $past(stall_cnt) + 1'b1);
  // R4
  beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_valid && r_ready) |=> $stable(beat_cnt));
  // R3
  bins_le_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bin_sum <= (CNT_W+3)'(beat_cnt));
  // R2
  one_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bin_hit));
  // R8
  no_bin_without_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_hs && occ[r_id] == '0 |=> bin_sum == $past(bin_sum));
  // R9
  sel_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel == 3'd7 |-> rd_data == '0);
endmodule

// File: tb/tb_rd_lat_hist.sv
module tb_rd_lat_hist;
  logic clk = 0, rst_n = 0;
  logic ar_valid = 0, ar_ready = 0, r_valid = 0, r_ready = 0, r_last = 0;
  logic [2:0] ar_id = 0, r_id = 0, rd_sel = 0;
  logic [31:0] rd_data;

  rd_lat_hist dut (.clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready),
    .ar_id(ar_id), .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_last(r_last),
    .rd_sel(rd_sel), .rd_data(rd_data));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  longint now = 0;
  longint qt [8][4];
  int hd [8], cnt [8];
  longint ex [7];
  bit done = 0;

  function automatic int bin_of(longint l);
    if (l < 128) return 0;
    if (l < 384) return int'((l - 128) / 64) + 1;
    return -1;
  endfunction

  task automatic step(bit av, bit ar, int aid, bit rv, bit rr, int rid, bit rl);
    bit afull;
    int apos;
    @(negedge clk);
    ar_valid = av; ar_ready = ar; ar_id = 3'(aid);
    r_valid = rv; r_ready = rr; r_id = 3'(rid); r_last = rl;
    afull = cnt[aid] >= 4;
    apos = (hd[aid] + cnt[aid]) % 4;
    if (rv && rr) begin
      ex[5]++;
      if (cnt[rid] > 0) begin
        int b;
        b = bin_of((now - qt[rid][hd[rid]]) % 65536);
        if (b >= 0) ex[b]++;
        if (rl) begin hd[rid] = (hd[rid] + 1) % 4; cnt[rid]--; end
      end
    end
    if (av && ar && !afull) begin qt[aid][apos] = now; cnt[aid]++; end
    if (av && !ar) ex[6]++;
    now++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic chk_all(string req);
    idle(1);
    for (int s = 0; s < 8; s++) begin
      longint e;
      rd_sel = 3'(s);
      #1;
      e = (s == 7) ? 0 : (ex[s] & 64'hFFFF_FFFF);
      n_chk++;
      if (longint'(rd_data) != e) begin
        n_bad++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", req, s, rd_data, e);
      end
    end
  endtask

  task automatic one_read(int id, int lat);
    step(1, 1, id, 0, 0, 0, 0);
    idle(lat - 1);
    step(0, 0, 0, 1, 1, id, 1);
  endtask

  initial begin
    #(20 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lats [12] = '{1, 127, 128, 191, 192, 255, 256, 319, 320, 383, 384, 500};
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin hd[i] = 0; cnt[i] = 0; end
    for (int i = 0; i < 7; i++) ex[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_all("R1");
    chk_all("R9");
    // R2 boundaries, R3 long latencies
    foreach (lats[k]) begin
      one_read(k % 8, lats[k]);
      chk_all(lats[k] >= 384 ? "R3" : "R2");
    end
    // R4 withheld beats and orphan beats
    step(0, 0, 0, 1, 0, 2, 1);
    step(0, 0, 0, 1, 0, 2, 1);
    step(0, 0, 0, 1, 1, 7, 1);
    chk_all("R4");
    // R5 stalled addresses
    step(1, 0, 1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0);
    idle(10);
    step(0, 0, 0, 1, 1, 1, 1);
    chk_all("R5");
    // R6 same ID bursts in order
    step(1, 1, 3, 0, 0, 0, 0);
    idle(100);
    step(1, 1, 3, 0, 0, 0, 0);
    idle(20);
    step(0, 0, 0, 1, 1, 3, 0);
    idle(10);
    step(0, 0, 0, 1, 1, 3, 1);
    step(0, 0, 0, 1, 1, 3, 0);
    idle(60);
    step(0, 0, 0, 1, 1, 3, 1);
    chk_all("R6");
    // R7 two IDs, out of order
    step(1, 1, 4, 0, 0, 0, 0);
    idle(130);
    step(1, 1, 6, 0, 0, 0, 0);
    idle(5);
    step(0, 0, 0, 1, 1, 6, 1);
    idle(60);
    step(0, 0, 0, 1, 1, 4, 1);
    chk_all("R7");
    // R8 overflow of one ID queue, then orphan beat
    for (int i = 0; i < 5; i++) begin step(1, 1, 5, 0, 0, 0, 0); idle(30); end
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1, 5, 1);
    step(0, 0, 0, 1, 1, 0, 1);
    chk_all("R8");
    // R10 cycle counter wrap
    idle(65536 - int'(now % 65536) - 150);
    one_read(2, 300);
    chk_all("R10");
    one_read(2, 200);
    chk_all("R10");
    // random rounds
    for (int rnd = 0; rnd < 25; rnd++) begin
      int pend;
      pend = 0;
      for (int t = 0; t < 6; t++) begin
        int id;
        id = int'($urandom_range(0, 7));
        while ($urandom_range(0, 2) == 0) step(1, 0, id, 0, 0, 0, 0);
        step(1, 1, id, 0, 0, 0, 0);
        idle(int'($urandom_range(0, 40)));
      end
      for (int i = 0; i < 8; i++) pend += cnt[i];
      while (pend > 0) begin
        int id, bl;
        id = int'($urandom_range(0, 7));
        while (cnt[id] == 0) id = (id + 1) % 8;
        bl = int'($urandom_range(1, 4));
        for (int b = 0; b < bl; b++) begin
          int g;
          g = int'($urandom_range(0, 120));
          for (int k = 0; k < g; k++)
            step($urandom_range(0, 9) == 0, 0, 0, $urandom_range(0, 5) == 0, 0, id, 0);
          step(0, 0, 0, 1, 1, id, b == bl - 1);
        end
        pend--;
      end
      chk_all(rnd % 2 == 0 ? "R2" : "R6");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule